// File: doc/BRIEF.md
# YCbCr 4:2:2 Component Sequencer

This block turns parallel 4:2:2 video samples (a luma value every pixel, a chroma pair every two pixels) into one component stream on a single bus, one component per pixel clock. Each output word comes with a tag that identifies it as Y, Cb or Cr. Two swap controls choose one of four repeating component orders. The first control decides whether luma or chroma leads each group. The second decides which chroma component comes first.

The horizontal sync pulse marks the start of a line. It returns the sequence to its first slot and loads the swap controls into the order register, so a line never changes order partway through. While the active-video flag is low, the slot position holds and the bus carries the standard blanking levels. The output register adds one clock of latency.

Top module: `ycc422_sequencer`

## Requirements
- R1: With order register {luma_first, chroma_swap} = 00, successive active slots carry Cb, Y, Cr, Y. Tag codes are Y = 2'b00, Cb = 2'b01 and Cr = 2'b10.
- R2: With order 01 (chroma_swap set), the active slots carry Cr, Y, Cb, Y.
- R3: With order 10 (luma_first set), the active slots carry Y, Cb, Y, Cr.
- R4: With order 11, the active slots carry Y, Cr, Y, Cb.
- R5: A cycle with `hsync` high uses slot 0. If `active` is also high in that cycle, the next cycle moves to slot 1; otherwise the block stays at slot 0.
- R6: The slot position advances by one (modulo 4) on each cycle with `active` high, and holds on each cycle with `active` low.
- R7: A slot taken while `active` is low outputs 0x80 for a chroma slot and 0x10 for a luma slot. The tag still names the slot's component.
- R8: The swap inputs are loaded into the order register only on a cycle with `hsync` high. Changes at any other time have no effect until the next `hsync`.
- R9: A luma slot outputs `y_in` from the same cycle. The first chroma slot of a group (slot 0 or 1) outputs its live chroma input and captures both `cb_in` and `cr_in`. The second chroma slot (slot 2 or 3) outputs the captured value for its own component.
- R10: The bus and tag are registered, and each reflects the inputs of the previous clock. After reset the block is at order 00, slot 0, the bus reads 0x80 with tag Cb, and both captured chroma values are 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync | input | 1 | Line start pulse: restarts the sequence and loads the order |
| active | input | 1 | Active-video flag |
| y_in | input | 8 | Luma sample of the current pixel |
| cb_in | input | 8 | Blue-difference sample of the current pixel pair |
| cr_in | input | 8 | Red-difference sample of the current pixel pair |
| swap_luma | input | 1 | Luma-first select, loaded at `hsync` |
| swap_chroma | input | 1 | Chroma-order select, loaded at `hsync` |
| px_out | output | 8 | Multiplexed component bus |
| comp_kind | output | 2 | Component tag: 00 Y, 01 Cb, 10 Cr |

## Verification
The hardest cases to reach come from combining three things: a swap change partway through a line, blanking gaps that leave the slot at an odd position, and a sync pulse arriving together with active video. In each case the second chroma slot must still show the value captured earlier, not the live input. The directed part of the stimulus builds each of these on purpose. A long random stretch then toggles the swap controls, the active flag and sync independently, so stale-capture and mid-line order errors show up as mismatches against the bench model.

// File: rtl/ycc_seq_pkg.sv
package ycc_seq_pkg;

    typedef enum logic [1:0] {
        KIND_Y  = 2'b00,
        KIND_CB = 2'b01,
        KIND_CR = 2'b10
    } comp_kind_e;

    typedef struct packed {
        logic luma_first;
        logic chroma_swap;
    } order_t;

    localparam int SLOT_W = 2;

    // Component carried by a slot under a given order.
    function automatic comp_kind_e slot_kind(order_t o, logic [SLOT_W-1:0] ph);
        logic luma_slot;
        luma_slot = o.luma_first ? ~ph[0] : ph[0];
        if (luma_slot) begin
            return KIND_Y;
        end
        // first chroma of group is Cb unless swapped
        if (ph[1] ^ o.chroma_swap) begin
            return KIND_CR;
        end
        return KIND_CB;
    endfunction

endpackage

// File: rtl/ycc_phase_ctl.sv
module ycc_phase_ctl
    import ycc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync,
    input  logic              active,
    input  order_t            swap_in,
    output order_t            ord_eff,
    output logic [SLOT_W-1:0] phase_eff
);

    order_t            ord_q;
    logic [SLOT_W-1:0] phase_q;

    always_comb begin
        ord_eff   = hsync ? swap_in : ord_q;
        phase_eff = hsync ? '0 : phase_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ord_q   <= '0;
            phase_q <= '0;
        end else begin
            ord_q   <= ord_eff;
            phase_q <= active ? phase_eff + 1'b1 : phase_eff;
        end
    end

    p_sync_restart_r5: assert property (@(posedge clk) disable iff (rst)
        (!rst && hsync) |=> (phase_q == {1'b0, $past(active)}));

    p_hold_blank_r6: assert property (@(posedge clk) disable iff (rst)
        (!rst && !hsync && !active) |=> (phase_q == $past(phase_q)));

    p_advance_r6: assert property (@(posedge clk) disable iff (rst)
        (!rst && !hsync && active) |=> (phase_q == $past(phase_q) + 2'd1));

    p_order_latched_r8: assert property (@(posedge clk) disable iff (rst)
        (!rst && !hsync) |=> (ord_q == $past(ord_q)));

endmodule

// File: rtl/ycc_chroma_hold.sv
module ycc_chroma_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          capture,
    input  logic [DW-1:0] cb_in,
    input  logic [DW-1:0] cr_in,
    output logic [DW-1:0] cb_q,
    output logic [DW-1:0] cr_q
);

    localparam logic [DW-1:0] CHROMA_MID = DW'(1) << (DW - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cb_q <= CHROMA_MID;
            cr_q <= CHROMA_MID;
        end else if (capture) begin
            cb_q <= cb_in;
            cr_q <= cr_in;
        end
    end

    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (!rst && !capture) |=> ($stable(cb_q) && $stable(cr_q)));

endmodule

// File: rtl/ycc_out_stage.sv
module ycc_out_stage
    import ycc_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          active,
    input  comp_kind_e    kind,
    input  logic          second_half,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] cb_in,
    input  logic [DW-1:0] cr_in,
    input  logic [DW-1:0] cb_held,
    input  logic [DW-1:0] cr_held,
    output logic [DW-1:0] px_q,
    output logic [1:0]    tag_q
);

    localparam logic [DW-1:0] CHROMA_BLANK = DW'(1) << (DW - 1);
    localparam logic [DW-1:0] LUMA_BLANK   = DW'(16) << (DW - 8);

    logic [DW-1:0] px_d;

    always_comb begin
        unique case (kind)
            KIND_Y:  px_d = active ? y_in : LUMA_BLANK;
            KIND_CB: px_d = !active ? CHROMA_BLANK : (second_half ? cb_held : cb_in);
            KIND_CR: px_d = !active ? CHROMA_BLANK : (second_half ? cr_held : cr_in);
            default: px_d = CHROMA_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            px_q  <= CHROMA_BLANK;
            tag_q <= KIND_CB;
        end else begin
            px_q  <= px_d;
            tag_q <= kind;
        end
    end

    p_blank_level_r7: assert property (@(posedge clk) disable iff (rst)
        (!rst && !active) |=>
            (px_q == ((tag_q == KIND_Y) ? LUMA_BLANK : CHROMA_BLANK)));

endmodule

// File: rtl/ycc422_sequencer.sv
module ycc422_sequencer
    import ycc_seq_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hsync,
    input  logic          active,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] cb_in,
    input  logic [DW-1:0] cr_in,
    input  logic          swap_luma,
    input  logic          swap_chroma,
    output logic [DW-1:0] px_out,
    output logic [1:0]    comp_kind
);

    order_t            swap_req;
    order_t            ord_eff;
    logic [SLOT_W-1:0] phase_eff;
    comp_kind_e        kind;
    logic              capture;
    logic [DW-1:0]     cb_held;
    logic [DW-1:0]     cr_held;

    always_comb begin
        swap_req.luma_first  = swap_luma;
        swap_req.chroma_swap = swap_chroma;
        kind    = slot_kind(ord_eff, phase_eff);
        capture = active && (kind != KIND_Y) && !phase_eff[SLOT_W-1];
    end

    ycc_phase_ctl u_phase (
        .clk       (clk),
        .rst       (rst),
        .hsync     (hsync),
        .active    (active),
        .swap_in   (swap_req),
        .ord_eff   (ord_eff),
        .phase_eff (phase_eff)
    );

    ycc_chroma_hold #(.DW(DW)) u_hold (
        .clk     (clk),
        .rst     (rst),
        .capture (capture),
        .cb_in   (cb_in),
        .cr_in   (cr_in),
        .cb_q    (cb_held),
        .cr_q    (cr_held)
    );

    ycc_out_stage #(.DW(DW)) u_out (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .kind        (kind),
        .second_half (phase_eff[SLOT_W-1]),
        .y_in        (y_in),
        .cb_in       (cb_in),
        .cr_in       (cr_in),
        .cb_held     (cb_held),
        .cr_held     (cr_held),
        .px_q        (px_out),
        .tag_q       (comp_kind)
    );

    // luma and chroma alternate on consecutive active slots within a line
    p_luma_alternates_r1: assert property (@(posedge clk) disable iff (rst)
        (!rst && active && !hsync && $past(!rst && active && !hsync)) |=>
            ((comp_kind == 2'b00) != ($past(comp_kind) == 2'b00)));

endmodule

// File: tb/test_ycc422_sequencer.sv
`timescale 1ns/1ps
module test_ycc422_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync = 1'b0;
    logic       active = 1'b0;
    logic [7:0] y_in = 8'h00;
    logic [7:0] cb_in = 8'h00;
    logic [7:0] cr_in = 8'h00;
    logic       swap_luma = 1'b0;
    logic       swap_chroma = 1'b0;
    logic [7:0] px_out;
    logic [1:0] comp_kind;

    int n_cmp = 0;
    int n_bad = 0;

    logic [1:0] m_phase = 2'd0;
    logic [1:0] m_ord = 2'd0;
    logic [7:0] m_hcb = 8'h80;
    logic [7:0] m_hcr = 8'h80;

    always #4 clk = ~clk;

    ycc422_sequencer i_ycc422_sequencer (
        .clk(clk), .rst(rst), .hsync(hsync), .active(active),
        .y_in(y_in), .cb_in(cb_in), .cr_in(cr_in),
        .swap_luma(swap_luma), .swap_chroma(swap_chroma),
        .px_out(px_out), .comp_kind(comp_kind)
    );

    // expected component per order and slot: 0=Y 1=Cb 2=Cr
    function automatic logic [1:0] exp_kind(input logic [1:0] o, input logic [1:0] ph);
        logic [7:0] seq;
        case (o)
            2'b00: seq = {2'd0, 2'd2, 2'd0, 2'd1}; // R1: Cb Y Cr Y
            2'b01: seq = {2'd0, 2'd1, 2'd0, 2'd2}; // R2: Cr Y Cb Y
            2'b10: seq = {2'd2, 2'd0, 2'd1, 2'd0}; // R3: Y Cb Y Cr
            default: seq = {2'd1, 2'd0, 2'd2, 2'd0}; // R4: Y Cr Y Cb
        endcase
        return seq[ph*2 +: 2];
    endfunction

    function automatic string order_req(input logic [1:0] o);
        case (o)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    task automatic compare(input string req, input logic [7:0] ep, input logic [1:0] ek);
        n_cmp++;
        if (px_out !== ep || comp_kind !== ek) begin
            n_bad++;
            $display("FAIL %s: px_out=%h kind=%0d expected px_out=%h kind=%0d",
                     req, px_out, comp_kind, ep, ek);
        end
    endtask

    // called at a falling edge; drives, models, checks at the next falling edge
    task automatic step(input logic hs, input logic act, input logic [7:0] yv,
                        input logic [7:0] cbv, input logic [7:0] crv,
                        input logic sl, input logic sc, input string lbl);
        logic [1:0] eo, ep_ph, k;
        logic [7:0] ev;
        string req;
        hsync = hs; active = act; y_in = yv; cb_in = cbv; cr_in = crv;
        swap_luma = sl; swap_chroma = sc;
        eo    = hs ? {sl, sc} : m_ord;
        ep_ph = hs ? 2'd0 : m_phase;
        k     = exp_kind(eo, ep_ph);
        if (!act)           ev = (k == 2'd0) ? 8'h10 : 8'h80;
        else if (k == 2'd0) ev = yv;
        else if (!ep_ph[1]) ev = (k == 2'd1) ? cbv : crv;
        else                ev = (k == 2'd1) ? m_hcb : m_hcr;
        if (act && k != 2'd0 && !ep_ph[1]) begin
            m_hcb = cbv;
            m_hcr = crv;
        end
        m_phase = act ? ep_ph + 2'd1 : ep_ph;
        m_ord   = eo;
        if (lbl != "")                  req = lbl;
        else if (!act)                  req = "R7";
        else if (hs)                    req = "R5";
        else if (k != 2'd0 && ep_ph[1]) req = "R9";
        else                            req = order_req(eo);
        @(negedge clk);
        compare(req, ev, k);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        compare("R10", 8'h80, 2'd1); // reset state
        rst = 1'b0;

        // each order over two pixel pairs
        for (int o = 0; o < 4; o++) begin
            step(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, o[1], o[0], "");
            for (int i = 0; i < 8; i++)
                step(1'b0, 1'b1, 8'h20 + 8'(i), 8'h40 + 8'(i), 8'hC0 + 8'(i),
                     o[1], o[0], "");
        end

        // R8: swap change mid-line has no effect until hsync
        step(1'b1, 1'b1, 8'h31, 8'h51, 8'h71, 1'b0, 1'b0, "R5");
        for (int i = 0; i < 6; i++)
            step(1'b0, 1'b1, 8'h32 + 8'(i), 8'h52, 8'h72, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b1, 8'h3A, 8'h5A, 8'h7A, 1'b1, 1'b1, "R8");
        step(1'b0, 1'b1, 8'h3B, 8'h5B, 8'h7B, 1'b0, 1'b0, "R8");

        // R6: blanking gap leaves slot at odd position, then resumes
        step(1'b1, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, "");
        step(1'b0, 1'b1, 8'h11, 8'hA1, 8'hB1, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 8'h12, 8'hA2, 8'hB2, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b0, 8'h13, 8'hA3, 8'hB3, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 8'h14, 8'hA4, 8'hB4, 1'b0, 1'b0, "R6");
        step(1'b0, 1'b1, 8'h15, 8'hA5, 8'hB5, 1'b0, 1'b0, "R9");
        step(1'b0, 1'b1, 8'h16, 8'hA6, 8'hB6, 1'b0, 1'b0, "R6");

        // R5: hsync mid-group with active video
        step(1'b1, 1'b1, 8'h61, 8'h62, 8'h63, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b1, 8'h64, 8'h65, 8'h66, 1'b1, 1'b0, "R5");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic hs, act, sl, sc;
            hs  = ($urandom_range(0, 29) == 0);
            act = ($urandom_range(0, 4) != 0);
            sl  = ($urandom_range(0, 7) == 0) ? ~swap_luma : swap_luma;
            sc  = ($urandom_range(0, 7) == 0) ? ~swap_chroma : swap_chroma;
            step(hs, act, 8'($urandom), 8'($urandom), 8'($urandom), sl, sc, "");
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule